// File: doc/BRIEF.md
# 4x4 Inverse Integer Transform Pipeline

This block turns a 4x4 block of signed 16-bit dequantized coefficients into a 4x4 block of signed 16-bit residual samples. It uses the separable integer inverse transform found in block-based video decoders. A four-point butterfly with half-weight odd taps runs over each row, then over each column of the row result, and a final stage rounds each value and divides it by 64.

Both sides of the block are full-width parallel buses with valid/ready handshakes. The sixteen coefficients arrive in one transfer and the sixteen samples leave in one transfer. Element k of either bus sits in bits [16k+15:16k] and stands for row k/4, column k%4.

The datapath has three register stages: row pass, column pass and rounding. One global advance condition moves the whole pipeline. Advance holds when the output register is empty or is being taken. A new block can therefore enter on every cycle in which downstream is ready.

Top module: `itx4x4_core`

## Requirements
- R1: For every row (d0..d3 = columns 0..3) the first pass computes e0=d0+d2, e1=d0-d2, e2=(d1>>1)-d3 and e3=d1+(d3>>1). It then forms f0=e0+e3, f1=e1+e2, f2=e1-e2 and f3=e0-e3 into columns 0..3 of that row.
- R2: The halving on the odd taps is an arithmetic right shift by one that floors: -1 halves to -1 and -3 halves to -2.
- R3: The same butterfly then runs on every column of the row-pass result, with d0..d3 = rows 0..3. Bus element k is row k/4, column k%4, in bits [16k+15:16k].
- R4: Each output sample is (x+32)>>6. The add of 32 is done in 16 bits, the shift is arithmetic, and the result is sign-extended to 16 bits.
- R5: Every sum and difference wraps modulo 2^16 in two's complement, with no saturation at any stage.
- R6: With out_ready held high, a block accepted at a clock edge shows out_valid high after the third edge, counting that one.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_res does not change on the next cycle.
- R9: Blocks leave in the order they were accepted, one per handshake, and none is lost or repeated, including under back-to-back input and random backpressure.
- R10: A synchronous active-high reset empties all three stages: out_valid is low and in_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient block offered |
| in_ready | output | 1 | Block accepted on this edge if in_valid |
| in_coef | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| out_valid | output | 1 | Residual block available |
| out_ready | input | 1 | Downstream takes the block |
| out_res | output | 256 | Sixteen signed 16-bit residual samples, raster order |

## Verification
A lane mapping or transpose error, or a wrong shift, shows up as wrong samples in out_res. With no backpressure this happens three edges after the block is accepted, so a directed pattern that excites a single coefficient points to the faulty lane. A stage valid flag that sticks or gets dropped shows up as a missing, extra or reordered block at the next output handshake. A wrong advance condition shows up at once, on the first cycle of backpressure, either as a changed out_res or as in_ready disagreeing with out_valid and out_ready.

// File: rtl/itx_pkg.sv
package itx_pkg;
    // Side of the square block; the butterfly is defined for four points only
    localparam int DIM   = 4;
    localparam int NELEM = DIM * DIM;

    // Which dimension a pass walks along
    typedef enum logic {
        PASS_ROW = 1'b0,
        PASS_COL = 1'b1
    } pass_e;
endpackage

// File: rtl/itx_bfly.sv
module itx_bfly #(
    parameter int LANE_W = 16
) (
    input  logic signed [LANE_W-1:0] d0,
    input  logic signed [LANE_W-1:0] d1,
    input  logic signed [LANE_W-1:0] d2,
    input  logic signed [LANE_W-1:0] d3,
    output logic signed [LANE_W-1:0] f0,
    output logic signed [LANE_W-1:0] f1,
    output logic signed [LANE_W-1:0] f2,
    output logic signed [LANE_W-1:0] f3
);
    logic signed [LANE_W-1:0] sum_ev, dif_ev, odd_lo, odd_hi;

    // Even part: plain sum and difference; odd part: half-weight taps
    always_comb begin
        sum_ev = d0 + d2;
        dif_ev = d0 - d2;
        odd_lo = (d1 >>> 1) - d3;
        odd_hi = d1 + (d3 >>> 1);
        f0 = sum_ev + odd_hi;
        f1 = dif_ev + odd_lo;
        f2 = dif_ev - odd_lo;
        f3 = sum_ev - odd_hi;
    end
endmodule

// File: rtl/itx_pass.sv
module itx_pass
    import itx_pkg::*;
#(
    parameter int    LANE_W = 16,
    parameter pass_e MODE   = PASS_ROW
) (
    input  logic [NELEM*LANE_W-1:0] blk_i,
    output logic [NELEM*LANE_W-1:0] blk_o
);
    // One butterfly per row or per column; the walk direction picks the lanes
    for (genvar v = 0; v < DIM; v++) begin : g_vec
        logic signed [LANE_W-1:0] din  [DIM];
        logic signed [LANE_W-1:0] dout [DIM];

        for (genvar j = 0; j < DIM; j++) begin : g_lane
            localparam int K = (MODE == PASS_ROW) ? (v * DIM + j) : (j * DIM + v);
            assign din[j]                 = blk_i[K*LANE_W +: LANE_W];
            assign blk_o[K*LANE_W +: LANE_W] = dout[j];
        end

        itx_bfly #(.LANE_W(LANE_W)) u_bfly (
            .d0(din[0]),  .d1(din[1]),  .d2(din[2]),  .d3(din[3]),
            .f0(dout[0]), .f1(dout[1]), .f2(dout[2]), .f3(dout[3])
        );
    end
endmodule

// File: rtl/itx_round.sv
module itx_round
    import itx_pkg::*;
#(
    parameter int LANE_W      = 16,
    parameter int SCALE_SHIFT = 6
) (
    input  logic [NELEM*LANE_W-1:0] blk_i,
    output logic [NELEM*LANE_W-1:0] blk_o
);
    localparam logic signed [LANE_W-1:0] BIAS = LANE_W'(1 << (SCALE_SHIFT - 1));

    for (genvar k = 0; k < NELEM; k++) begin : g_rnd
        logic signed [LANE_W-1:0] raw, biased;
        assign raw    = blk_i[k*LANE_W +: LANE_W];
        assign biased = raw + BIAS;
        assign blk_o[k*LANE_W +: LANE_W] = biased >>> SCALE_SHIFT;
    end
endmodule

// File: rtl/itx4x4_core.sv
module itx4x4_core
    import itx_pkg::*;
#(
    parameter int LANE_W      = 16,
    parameter int SCALE_SHIFT = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NELEM*LANE_W-1:0]   in_coef,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [NELEM*LANE_W-1:0]   out_res
);
    localparam int BUS_W = NELEM * LANE_W;

    logic             adv;
    logic             s1_v, s2_v;
    logic [BUS_W-1:0] s1_d, s2_d;
    logic [BUS_W-1:0] row_c, col_c, rnd_c;

    // The pipeline moves as one when the output slot is free or draining
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    itx_pass #(.LANE_W(LANE_W), .MODE(PASS_ROW)) u_rows (
        .blk_i(in_coef), .blk_o(row_c)
    );

    itx_pass #(.LANE_W(LANE_W), .MODE(PASS_COL)) u_cols (
        .blk_i(s1_d), .blk_o(col_c)
    );

    itx_round #(.LANE_W(LANE_W), .SCALE_SHIFT(SCALE_SHIFT)) u_rnd (
        .blk_i(s2_d), .blk_o(rnd_c)
    );

    // Stage occupancy flags
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v      <= 1'b0;
            s2_v      <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            s1_v      <= in_valid;
            s2_v      <= s1_v;
            out_valid <= s2_v;
        end
    end

    // Stage payloads carry no reset
    always_ff @(posedge clk) begin
        if (adv) begin
            s1_d    <= row_c;
            s2_d    <= col_c;
            out_res <= rnd_c;
        end
    end
endmodule

// File: rtl/itx4x4_chk.sv
module itx4x4_chk #(
    parameter int BUS_W = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BUS_W-1:0] out_res,
    input logic             s1_v,
    input logic             s2_v
);
    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !s1_v && !s2_v));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

    // R9
    pipe_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(s1_v) && $stable(s2_v)));

    // R9
    accept_land_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> s1_v);

    // R6
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_v && in_ready) |=> out_valid);
endmodule

bind itx4x4_core itx4x4_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .s1_v(s1_v), .s2_v(s2_v)
);

// File: tb/sim_itx4x4_core.sv
`timescale 1ns/1ps
module sim_itx4x4_core;
    localparam int W  = 16;
    localparam int BW = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [BW-1:0] in_coef = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [BW-1:0] out_res;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int rdy_mode = 0;        // 0: always ready, 1: random, 2: held low
    bit lat_check = 1'b0;
    bit prev_stall = 1'b0;
    logic [BW-1:0] prev_res;
    logic [BW-1:0] exp_q[$];
    string         tag_q[$];
    int            acc_q[$];
    string         cur_tag = "R1";

    always #4 clk = ~clk;    // 125 MHz

    itx4x4_core u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
        .out_res(out_res)
    );

    function automatic int w16(input int v);
        int r;
        r = v & 32'hFFFF;
        if (r >= 32768) r -= 65536;
        return r;
    endfunction

    // Reference: integer arithmetic per the requirements
    function automatic logic [BW-1:0] ref_blk(input logic [BW-1:0] c);
        int m[16];
        int a[4];
        int e0, e1, e2, e3;
        logic [BW-1:0] r;
        for (int k = 0; k < 16; k++) m[k] = int'($signed(c[k*16 +: 16]));
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 4; v++) begin
                for (int j = 0; j < 4; j++) a[j] = (p == 0) ? m[v*4+j] : m[j*4+v];
                e0 = w16(a[0] + a[2]);
                e1 = w16(a[0] - a[2]);
                e2 = w16((a[1] >>> 1) - a[3]);
                e3 = w16(a[1] + (a[3] >>> 1));
                a[0] = w16(e0 + e3);
                a[1] = w16(e1 + e2);
                a[2] = w16(e1 - e2);
                a[3] = w16(e0 - e3);
                for (int j = 0; j < 4; j++)
                    if (p == 0) m[v*4+j] = a[j]; else m[j*4+v] = a[j];
            end
        end
        for (int k = 0; k < 16; k++) r[k*16 +: 16] = 16'(w16(w16(m[k] + 32) >>> 6));
        return r;
    endfunction

    function automatic logic [BW-1:0] one_hot(input int k, input int val);
        logic [BW-1:0] b;
        b = '0;
        b[k*16 +: 16] = 16'(val);
        return b;
    endfunction

    // Monitor, between edges: inputs were driven at posedge+1
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            checks++;
            if (in_ready !== (!out_valid || out_ready)) begin
                errors++;
                $display("FAIL R7 in_ready=%0b expected %0b", in_ready, (!out_valid || out_ready));
            end
            if (prev_stall) begin
                checks++;
                if (out_valid !== 1'b1 || out_res !== prev_res) begin
                    errors++;
                    $display("FAIL R8 valid=%0b res=%h expected valid=1 res=%h", out_valid, out_res, prev_res);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_res   = out_res;
            if (in_valid && in_ready) begin
                exp_q.push_back(ref_blk(in_coef));
                tag_q.push_back(cur_tag);
                acc_q.push_back(cyc);
            end
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9 unexpected block %h expected none", out_res);
                end else begin
                    logic [BW-1:0] e;
                    string t;
                    int a;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    a = acc_q.pop_front();
                    if (out_res !== e) begin
                        errors++;
                        $display("FAIL %s R9 block %h expected %h", t, out_res, e);
                    end
                    if (lat_check) begin
                        checks++;
                        if (cyc - a != 3) begin
                            errors++;
                            $display("FAIL R6 latency %0d expected 3", cyc - a);
                        end
                    end
                end
            end
        end
    end

    // Downstream readiness
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = ($urandom % 4) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    task automatic send(input logic [BW-1:0] b, input string tag);
        bit acc;
        in_coef  = b;
        in_valid = 1'b1;
        cur_tag  = tag;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired, %0d blocks outstanding", exp_q.size());
        finish_run();
    end

    initial begin
        logic [BW-1:0] b;
        idle(3);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 out_valid=%0b expected 0", out_valid);
        end
        checks++;
        if (in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R10 in_ready=%0b expected 1", in_ready);
        end
        @(posedge clk);
        #1;

        // Directed patterns with fixed latency (R6)
        lat_check = 1'b1;
        send(one_hot(0, 64), "R4");          // DC: every sample 1
        idle(4);
        send(one_hot(0, -32), "R4");         // rounds to 0
        send(one_hot(0, -33), "R4");         // rounds to -1
        send(one_hot(1, -1), "R2");          // odd tap halving of -1
        send(one_hot(3, -3), "R2");          // odd tap halving of -3
        for (int k = 0; k < 16; k++) send(one_hot(k, 448), "R3");
        b = '0;
        for (int k = 0; k < 16; k++) b[k*16 +: 16] = 16'sh7FFF;
        send(b, "R5");
        for (int k = 0; k < 16; k++) b[k*16 +: 16] = 16'sh8000;
        send(b, "R5");
        for (int k = 0; k < 16; k++) b[k*16 +: 16] = 16'((k * 37) - 300);
        send(b, "R1");
        idle(6);
        lat_check = 1'b0;

        // Held stall with blocks in flight (R8, R9)
        rdy_mode = 2;
        for (int i = 0; i < 3; i++) begin
            for (int k = 0; k < 16; k++) b[k*16 +: 16] = 16'($urandom % 2048) - 16'd1024;
            send(b, "R8");
        end
        idle(5);
        rdy_mode = 0;
        idle(5);

        // Random stream under random backpressure (R9, R5)
        rdy_mode = 1;
        for (int i = 0; i < 80; i++) begin
            for (int k = 0; k < 16; k++)
                b[k*16 +: 16] = (i % 2 == 0) ? 16'($urandom) : (16'($urandom % 512) - 16'd256);
            send(b, "R9");
            if ($urandom % 5 == 0) idle(1);
        end
        rdy_mode = 0;
        while (exp_q.size() != 0) idle(1);
        idle(3);
        finish_run();
    end
endmodule